// File: doc/BRIEF.md
# Key-Protected Watchdog Restart Register

This block is a watchdog timer with one byte-wide control register on a simple synchronous register bus. The only way to restart the watchdog count is to write the restart key 0xAC to that register. Any other written byte is treated as a fault, and so is any single-bit (bit-manipulation) access to the register. A fault raises the internal reset request. When counting is enabled and the count reaches the programmed overflow value with no valid key write, the block also raises the reset request.

A read of the register never returns the value that was written. It returns a fixed status byte that shows whether counting is enabled. A gating input stops the watchdog source clock. If a fault occurs while that clock is stopped, the request is held pending and is issued once the clock runs again. The request leaves the block as a registered pulse, for use by the chip's reset controller.

Top module: `wdt_key_guard`

## Requirements
- R1: A byte write of 0xAC to the register address, with the bit-access flag low, clears the counter to zero and raises no reset request.
- R2: A byte write of any value other than 0xAC to the register address raises `wdtRstReq` on the clock edge that takes the write, when the source clock is running.
- R3: Any access to the register address with `busBitOp` high raises `wdtRstReq` on the same edge, whatever the data. This holds for a write or a read.
- R4: A read of the register address returns 0x9A on `busRdata` when `cfgRunEn` is 1 and 0x1A when it is 0, in the same cycle as the read. This is also the value during reset.
- R5: Accesses to any other address have no effect. Writes there raise no request, and reads there return 0x00.
- R6: While `srcClkOn` is 0, `wdtRstReq` stays low. A fault made in that time is kept pending, and `wdtRstReq` rises on the first clock edge at which `srcClkOn` is 1.
- R7: With `cfgRunEn` = 1 and `srcClkOn` = 1, a key write starts the count at 0 and the counter advances once per cycle. `wdtRstReq` rises on the edge that finds the count equal to `ovfLimit`, which is the (`ovfLimit`+1)th edge after the key write. A key write made earlier restarts this interval.
- R8: With `cfgRunEn` = 0 the counter holds, and no overflow request is raised.
- R9: `wdtRstReq` is a pulse one cycle long. It is never high for two edges in a row.
- R10: While `rstN` is low, and after it is released, `wdtRstReq` is 0. Reset also clears the counter and any pending fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and watchdog clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the access |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 8 | Write data |
| busBitOp | input | 1 | The access is a single-bit manipulation |
| cfgRunEn | input | 1 | 1 = watchdog counting enabled |
| srcClkOn | input | 1 | 1 = watchdog source clock running |
| ovfLimit | input | CNT_W | Overflow count value |
| busRdata | output | 8 | Read data, combinational |
| wdtRstReq | output | 1 | Internal reset request pulse |

## Verification
Read data is combinational, so the bench samples it 1 ns after it drives the read, in the same cycle. A fault request is registered on the edge that takes the access. The bench therefore samples it at the falling edge after that edge, and again one cycle later to confirm that the pulse has ended. For a pending fault, the bench samples at the falling edge after the first edge at which the clock gate is open. For overflow, the bench counts edges from the key write and expects the request exactly at edge `ovfLimit`+1, with a low request at every earlier edge.

// File: rtl/wdk_pkg.sv
package wdk_pkg;
  localparam logic [7:0] KEY_RESTART = 8'hAC;
  localparam logic [7:0] STAT_RUN    = 8'h9A;
  localparam logic [7:0] STAT_IDLE   = 8'h1A;

  typedef struct packed {
    logic restart;
    logic cntClr;
    logic readHit;
  } ctrlStrb_t;
endpackage

// File: rtl/wdt_key_ctrl.sv
module wdt_key_ctrl
  import wdk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h9B
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  input  logic              busBitOp,
  input  logic              srcClkOn,
  input  logic              ovfHit,
  output ctrlStrb_t         strb,
  output logic              wdtRstReq
);
  logic regHit, wrAccess, badAccess, fire, reqNext, pendQ;

  assign regHit    = (busAddr == REG_ADDR);
  assign wrAccess  = regHit & busWr;
  assign badAccess = (regHit & busBitOp & (busWr | busRd)) |
                     (wrAccess & (busWdata != KEY_RESTART));

  // A fault fires only while the source clock runs and no pulse is active.
  assign fire    = srcClkOn & (pendQ | badAccess) & !wdtRstReq;
  assign reqNext = fire | (ovfHit & !wdtRstReq);

  assign strb.restart = wrAccess & !busBitOp & (busWdata == KEY_RESTART);
  assign strb.cntClr  = reqNext | ovfHit;
  assign strb.readHit = regHit & busRd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ     <= 1'b0;
      wdtRstReq <= 1'b0;
    end else begin
      pendQ     <= (pendQ | badAccess) & !fire;
      wdtRstReq <= reqNext;
    end
  end
endmodule

// File: rtl/wdt_key_dp.sv
module wdt_key_dp
  import wdk_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgRunEn,
  input  logic             srcClkOn,
  input  logic [CNT_W-1:0] ovfLimit,
  input  ctrlStrb_t        strb,
  output logic             ovfHit,
  output logic [7:0]       busRdata
);
  logic [CNT_W-1:0] count;
  logic             tick;

  assign tick   = cfgRunEn & srcClkOn;
  assign ovfHit = tick & (count == ovfLimit) & !strb.restart;

  always_ff @(posedge clk) begin
    if (!rstN)
      count <= '0;
    else if (strb.restart || strb.cntClr)
      count <= '0;
    else if (tick)
      count <= count + 1'b1;
  end

  assign busRdata = strb.readHit ? (cfgRunEn ? STAT_RUN : STAT_IDLE) : 8'h00;
endmodule

// File: rtl/wdt_key_guard.sv
module wdt_key_guard
  import wdk_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h9B,
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [7:0]        busWdata,
  input  logic              busBitOp,
  input  logic              cfgRunEn,
  input  logic              srcClkOn,
  input  logic [CNT_W-1:0]  ovfLimit,
  output logic [7:0]        busRdata,
  output logic              wdtRstReq
);
  ctrlStrb_t strb;
  logic      ovfHit;

  wdt_key_ctrl #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busBitOp(busBitOp), .srcClkOn(srcClkOn),
    .ovfHit(ovfHit), .strb(strb), .wdtRstReq(wdtRstReq)
  );

  wdt_key_dp #(.CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgRunEn(cfgRunEn), .srcClkOn(srcClkOn),
    .ovfLimit(ovfLimit), .strb(strb), .ovfHit(ovfHit), .busRdata(busRdata)
  );
endmodule

// File: rtl/wdt_key_guard_chk.sv
module wdt_key_guard_chk #(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR = 'h9B
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWr,
  input logic              busRd,
  input logic [7:0]        busWdata,
  input logic              busBitOp,
  input logic              cfgRunEn,
  input logic              srcClkOn,
  input logic [7:0]        busRdata,
  input logic              wdtRstReq
);
  p_bad_key_r2: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == REG_ADDR && busWdata != 8'hAC && srcClkOn && !wdtRstReq)
      |=> wdtRstReq);

  p_bit_access_r3: assert property (@(posedge clk) disable iff (!rstN)
    ((busWr || busRd) && busBitOp && busAddr == REG_ADDR && srcClkOn && !wdtRstReq)
      |=> wdtRstReq);

  p_status_read_r4: assert property (@(posedge clk) disable iff (!rstN)
    (busRd && busAddr == REG_ADDR) |-> busRdata == (cfgRunEn ? 8'h9A : 8'h1A));

  p_other_addr_r5: assert property (@(posedge clk) disable iff (!rstN)
    !(busRd && busAddr == REG_ADDR) |-> busRdata == 8'h00);

  p_gated_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    !srcClkOn |=> !wdtRstReq);

  p_single_pulse_r9: assert property (@(posedge clk) disable iff (!rstN)
    wdtRstReq |=> !wdtRstReq);
endmodule

bind wdt_key_guard wdt_key_guard_chk #(.ADDR_W(ADDR_W), .REG_ADDR(REG_ADDR)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .busWdata(busWdata), .busBitOp(busBitOp), .cfgRunEn(cfgRunEn),
  .srcClkOn(srcClkOn), .busRdata(busRdata), .wdtRstReq(wdtRstReq)
);

// File: tb/wdt_key_guard_tb.sv
`timescale 1ns/1ps
module wdt_key_guard_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = 8'h00;
  logic        busWr = 1'b0, busRd = 1'b0, busBitOp = 1'b0;
  logic [7:0]  busWdata = 8'h00;
  logic        cfgRunEn = 1'b1, srcClkOn = 1'b1;
  logic [15:0] ovfLimit = 16'hFFFF;
  logic [7:0]  busRdata;
  logic        wdtRstReq;
  int          nChecks = 0, nFails = 0, cycles = 0;

  always #4 clk = ~clk;

  wdt_key_guard u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busBitOp(busBitOp), .cfgRunEn(cfgRunEn),
    .srcClkOn(srcClkOn), .ovfLimit(ovfLimit), .busRdata(busRdata),
    .wdtRstReq(wdtRstReq)
  );

  typedef struct packed {
    logic [7:0] addr;
    logic       wr;
    logic       rd;
    logic       bitOp;
    logic [7:0] data;
    logic       expReq;
    logic [7:0] expRd;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{8'h9B, 1'b1, 1'b0, 1'b0, 8'hAC, 1'b0, 8'h00}, // R1 key
    '{8'h9B, 1'b1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h00}, // R2 zero
    '{8'h9B, 1'b1, 1'b0, 1'b0, 8'hFF, 1'b1, 8'h00}, // R2 all ones
    '{8'h9B, 1'b1, 1'b0, 1'b1, 8'hAC, 1'b1, 8'h00}, // R3 bit write of key
    '{8'h9B, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h9A}, // R4 status read
    '{8'h9C, 1'b1, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00}, // R5 foreign write
    '{8'h9C, 1'b0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00}, // R5 foreign read
    '{8'h9B, 1'b0, 1'b1, 1'b1, 8'h00, 1'b1, 8'h9A}  // R3 bit read
  };

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at a falling edge, sample read data 1 ns later, request after the next rising edge.
  task automatic access(input logic [7:0] a, input logic w, input logic r,
                        input logic b, input logic [7:0] d,
                        output logic [7:0] rdOut, output logic reqOut);
    @(negedge clk);
    busAddr = a; busWr = w; busRd = r; busBitOp = b; busWdata = d;
    #1 rdOut = busRdata;
    @(negedge clk);
    reqOut = wdtRstReq;
    busWr = 1'b0; busRd = 1'b0; busBitOp = 1'b0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      nFails++;
      $display("FAIL timeout watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    logic       rq;

    // R10 reset state, R4 status during reset
    busAddr = 8'h9B; busRd = 1'b1;
    repeat (3) @(negedge clk);
    check("R10 req in reset", {7'd0, wdtRstReq}, 8'h00);
    check("R4 status in reset", busRdata, 8'h9A);
    busRd = 1'b0;
    rstN = 1'b1;
    @(negedge clk);
    check("R10 req after reset", {7'd0, wdtRstReq}, 8'h00);

    for (int i = 0; i < NVEC; i++) begin
      access(VECS[i].addr, VECS[i].wr, VECS[i].rd, VECS[i].bitOp, VECS[i].data, rd, rq);
      check($sformatf("vector %0d req", i), {7'd0, rq}, {7'd0, VECS[i].expReq});
      check($sformatf("vector %0d rdata", i), rd, VECS[i].expRd);
      @(negedge clk);
      check($sformatf("R9 vector %0d pulse end", i), {7'd0, wdtRstReq}, 8'h00);
    end

    // R4 with counting disabled
    cfgRunEn = 1'b0;
    access(8'h9B, 1'b0, 1'b1, 1'b0, 8'h00, rd, rq);
    check("R4 status idle", rd, 8'h1A);

    // R8 no overflow while disabled
    ovfLimit = 16'd3;
    access(8'h9B, 1'b1, 1'b0, 1'b0, 8'hAC, rd, rq);
    rq = 1'b0;
    repeat (10) begin @(negedge clk); rq = rq | wdtRstReq; end
    check("R8 no overflow when disabled", {7'd0, rq}, 8'h00);
    cfgRunEn = 1'b1;

    // R7 overflow on edge ovfLimit+1 after key write
    ovfLimit = 16'd5;
    access(8'h9B, 1'b1, 1'b0, 1'b0, 8'hAC, rd, rq);
    check("R1 key gives no request", {7'd0, rq}, 8'h00);
    for (int k = 1; k <= 6; k++) begin
      @(negedge clk);
      check($sformatf("R7 edge %0d", k), {7'd0, wdtRstReq}, {7'd0, k == 6});
    end
    @(negedge clk);
    check("R9 overflow pulse end", {7'd0, wdtRstReq}, 8'h00);

    // R1 key write restarts the interval
    access(8'h9B, 1'b1, 1'b0, 1'b0, 8'hAC, rd, rq);
    repeat (3) @(negedge clk);
    access(8'h9B, 1'b1, 1'b0, 1'b0, 8'hAC, rd, rq);
    rq = 1'b0;
    for (int k = 1; k <= 5; k++) begin @(negedge clk); rq = rq | wdtRstReq; end
    check("R1 restart delays overflow", {7'd0, rq}, 8'h00);
    @(negedge clk);
    check("R1 overflow after restart", {7'd0, wdtRstReq}, 8'h01);
    ovfLimit = 16'hFFFF;
    access(8'h9B, 1'b1, 1'b0, 1'b0, 8'hAC, rd, rq);

    // R6 fault while source clock stopped
    srcClkOn = 1'b0;
    access(8'h9B, 1'b1, 1'b0, 1'b0, 8'h55, rd, rq);
    repeat (3) begin @(negedge clk); rq = rq | wdtRstReq; end
    check("R6 held while gated", {7'd0, rq}, 8'h00);
    srcClkOn = 1'b1;
    @(negedge clk);
    check("R6 issued on resume", {7'd0, wdtRstReq}, 8'h01);
    @(negedge clk);
    check("R9 pending pulse end", {7'd0, wdtRstReq}, 8'h00);

    // R10 reset clears a pending fault
    srcClkOn = 1'b0;
    access(8'h9B, 1'b1, 1'b0, 1'b1, 8'h01, rd, rq);
    rstN = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    srcClkOn = 1'b1;
    rq = 1'b0;
    repeat (3) begin @(negedge clk); rq = rq | wdtRstReq; end
    check("R10 pending cleared by reset", {7'd0, rq}, 8'h00);

    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule